// File: doc/BRIEF.md
# Global-History Direction Predictor with Return Stack

This block sits in the fetch stage of a processor front end. For every conditional branch seen at fetch, it gives a taken or not-taken guess. That guess comes from a table of 256 two-bit saturating counters. The table is indexed only by an 8-bit global history of recent branch directions; the branch address plays no part. For every function call it saves the return address on a four-entry stack. For every function return it offers the saved address as the predicted target. The guesses come out in the same cycle as the lookup, so fetch can steer before the branch reaches execute.

The history is updated speculatively. Each accepted conditional branch shifts its own predicted direction into the history. It also leaves a checkpoint in a small in-order queue. The checkpoint holds the history that indexed the branch's counter, the predicted direction, and the return-stack pointer and fill count at that moment.

Execute reports branch outcomes in lookup order on a resolve stream, and the block compares each outcome with its stored guess. A correct guess trains the counter and retires the checkpoint; the pipeline does not flush. A wrong guess does the following:
- It trains the counter.
- It rebuilds the history from the checkpoint plus the real outcome.
- It rewinds the return stack.
- It drops every younger checkpoint.
- It raises a flush to fetch in the next cycle.

Lookup and resolve are both valid/ready streams. A transfer happens only in a cycle where valid and ready are both high. While valid is high, the sender must hold its payload steady until the transfer happens. Ready does not depend on the stream's own valid. A lookup that is not accepted changes no state. The combinational prediction outputs still show what the current state would give.

Top module: `ghist_predictor`

## Requirements
- R1: After reset, all counters hold 01 (weakly not-taken), the history is zero, the return stack is empty, no branch is in flight (rs_ready low), lk_ready is high and flush is low.
- R2: lk_pred_taken is combinational and equals the most significant bit of the counter selected by the current 8-bit global history.
- R3: An accepted lookup with lk_kind 01 (conditional branch) shifts the history left by one and puts the predicted direction in bit 0. Lookups of kind 00 (plain), 10 (call) and 11 (return) leave the history unchanged.
- R4: An accepted resolve trains the counter that its branch used at lookup time. Taken adds one, saturating at 11. Not-taken subtracts one, saturating at 00.
- R5: A resolve whose rs_taken differs from the stored guess is a mispredict. flush is high in the cycle after the resolve is accepted. The history becomes the checkpointed history shifted left with the real outcome in bit 0. All in-flight branches are discarded, so rs_ready is low while flush is high.
- R6: An accepted call (kind 10) pushes lk_ret_addr. A return lookup (kind 11) on a non-empty stack shows lk_ret_valid high with lk_ret_target equal to the most recently pushed address that has not yet been popped. It pops that address when accepted.
- R7: The return stack holds four addresses. A fifth call without returns overwrites the oldest entry, so only the four newest calls can be popped, in reverse order.
- R8: A return lookup on an empty stack gives lk_ret_valid low and leaves the stack unchanged.
- R9: A mispredict puts the return-stack pointer and fill count back to their values when the mispredicted branch was looked up.
- R10: lk_ready is low when four branches are in flight, and in a cycle where an accepted resolve mispredicts. rs_ready is low when no branch is in flight. Transfers that are not accepted have no effect.
- R11: Resolves are matched to branches in the order the branches were looked up.
- R12: When a lookup and a resolve that trains the same counter are accepted in the same cycle, the lookup's prediction uses the counter value from before training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_kind | input | 2 | 00 plain, 01 conditional branch, 10 call, 11 return |
| lk_ret_addr | input | ADDR_W (32) | Return address pushed by a call |
| lk_pred_taken | output | 1 | Predicted direction for the current history |
| lk_ret_valid | output | 1 | Return target prediction is valid |
| lk_ret_target | output | ADDR_W (32) | Predicted return address |
| rs_valid | input | 1 | Resolve of the oldest in-flight branch valid |
| rs_ready | output | 1 | A branch is in flight and can be resolved |
| rs_taken | input | 1 | Actual direction of the resolved branch |
| flush | output | 1 | Mispredict: flush and refetch, one cycle after the resolve |

## Verification
Two functions can land in the same cycle: a new lookup and the training of a resolved branch. The bench provokes this many times by driving both streams at once. A run of not-taken guesses keeps the history at zero, so the resolve writes the very counter the lookup reads. The prediction is judged against a bench model that samples counters before applying training. The second overlap is a mispredicting resolve next to a waiting lookup. There the model expects lk_ready to drop, and it expects that lookup's call or branch to leave no trace in the stack or the history.

// File: rtl/ghist_pkg.sv
package ghist_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'b00,
    K_COND  = 2'b01,
    K_CALL  = 2'b10,
    K_RET   = 2'b11
  } lk_kind_e;
endpackage

// File: rtl/ghist_ctr_table.sv
module ghist_ctr_table #(
  parameter int HIST_W = 8,
  parameter int CTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output logic              rd_taken,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);
  localparam int ENTRIES = 1 << HIST_W;
  localparam logic [CTR_W-1:0] WEAK_NT = CTR_W'((1 << (CTR_W - 1)) - 1);
  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] ctr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctr[g] <= WEAK_NT;
      end else if (wr_en && wr_idx == HIST_W'(g)) begin
        if (wr_taken) begin
          if (ctr[g] != CTR_MAX) ctr[g] <= ctr[g] + 1'b1;
        end else begin
          if (ctr[g] != '0) ctr[g] <= ctr[g] - 1'b1;
        end
      end
    end
  end

  assign rd_taken = ctr[rd_idx][CTR_W-1];
endmodule

// File: rtl/ghist_ret_stack.sv
module ghist_ret_stack #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  input  logic              restore,
  input  logic [PW-1:0]     restore_ptr,
  input  logic [CW-1:0]     restore_cnt,
  output logic [ADDR_W-1:0] top_addr,
  output logic [PW-1:0]     ptr,
  output logic [CW-1:0]     cnt
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PW-1:0] ptr_q, ptr_up, ptr_dn;
  logic [CW-1:0] cnt_q;

  assign ptr_up = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dn = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (restore) begin
      ptr_q <= restore_ptr;
      cnt_q <= restore_cnt;
    end else if (push) begin
      ptr_q <= ptr_up;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop && cnt_q != '0) begin
      ptr_q <= ptr_dn;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!restore && push) mem[ptr_up] <= push_addr;
  end

  assign top_addr = mem[ptr_q];
  assign ptr      = ptr_q;
  assign cnt      = cnt_q;
endmodule

// File: rtl/ghist_ckpt_queue.sv
module ghist_ckpt_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         clear,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0] mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q, rd_nx, wr_nx;
  logic [CW-1:0] n_q;

  assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
  assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_q <= '0;
      wr_q <= '0;
      n_q  <= '0;
    end else begin
      if (push) wr_q <= wr_nx;
      if (pop)  rd_q <= rd_nx;
      if (push && !pop)      n_q <= n_q + 1'b1;
      else if (pop && !push) n_q <= n_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_q] <= push_data;
  end

  assign head  = mem[rd_q];
  assign full  = (n_q == CW'(DEPTH));
  assign empty = (n_q == '0);
endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor #(
  parameter int HIST_W     = 8,
  parameter int CTR_W      = 2,
  parameter int RAS_DEPTH  = 4,
  parameter int CKPT_DEPTH = 4,
  parameter int ADDR_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [1:0]        lk_kind,
  input  logic [ADDR_W-1:0] lk_ret_addr,
  output logic              lk_pred_taken,
  output logic              lk_ret_valid,
  output logic [ADDR_W-1:0] lk_ret_target,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic              rs_taken,
  output logic              flush
);
  import ghist_pkg::*;

  localparam int RAS_PW = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1;
  localparam int RAS_CW = $clog2(RAS_DEPTH + 1);
  localparam int CK_W   = HIST_W + 1 + RAS_PW + RAS_CW;

  lk_kind_e          kind;
  logic [HIST_W-1:0] hist_q;
  logic              lk_acc, rs_acc, mispred;
  logic              ck_full, ck_empty;
  logic [CK_W-1:0]   ck_in, ck_head;
  logic [HIST_W-1:0] h_hist;
  logic              h_pred;
  logic [RAS_PW-1:0] h_ptr, ras_ptr;
  logic [RAS_CW-1:0] h_cnt, ras_cnt;
  logic [ADDR_W-1:0] ras_top;
  logic              flush_q;

  assign kind = lk_kind_e'(lk_kind);

  assign h_hist = ck_head[CK_W-1 -: HIST_W];
  assign h_pred = ck_head[RAS_PW + RAS_CW];
  assign h_ptr  = ck_head[RAS_CW +: RAS_PW];
  assign h_cnt  = ck_head[0 +: RAS_CW];

  assign rs_ready = !ck_empty;
  assign rs_acc   = rs_valid && rs_ready;
  assign mispred  = rs_acc && (rs_taken != h_pred);
  assign lk_ready = !ck_full && !mispred;
  assign lk_acc   = lk_valid && lk_ready;

  ghist_ctr_table #(.HIST_W(HIST_W), .CTR_W(CTR_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (hist_q),
    .rd_taken (lk_pred_taken),
    .wr_en    (rs_acc),
    .wr_idx   (h_hist),
    .wr_taken (rs_taken)
  );

  ghist_ret_stack #(.DEPTH(RAS_DEPTH), .ADDR_W(ADDR_W)) u_ras (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (lk_acc && kind == K_CALL),
    .push_addr   (lk_ret_addr),
    .pop         (lk_acc && kind == K_RET),
    .restore     (mispred),
    .restore_ptr (h_ptr),
    .restore_cnt (h_cnt),
    .top_addr    (ras_top),
    .ptr         (ras_ptr),
    .cnt         (ras_cnt)
  );

  assign ck_in = {hist_q, lk_pred_taken, ras_ptr, ras_cnt};

  ghist_ckpt_queue #(.DEPTH(CKPT_DEPTH), .W(CK_W)) u_ckpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (lk_acc && kind == K_COND),
    .push_data (ck_in),
    .pop       (rs_acc && !mispred),
    .clear     (mispred),
    .head      (ck_head),
    .full      (ck_full),
    .empty     (ck_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q  <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= mispred;
      if (mispred)
        hist_q <= {h_hist[HIST_W-2:0], rs_taken};
      else if (lk_acc && kind == K_COND)
        hist_q <= {hist_q[HIST_W-2:0], lk_pred_taken};
    end
  end

  assign lk_ret_valid  = lk_valid && kind == K_RET && ras_cnt != '0;
  assign lk_ret_target = ras_top;
  assign flush         = flush_q;
endmodule

// File: rtl/ghist_predictor_chk.sv
module ghist_predictor_chk #(
  parameter int HIST_W    = 8,
  parameter int RAS_DEPTH = 4,
  parameter int RAS_CW    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [1:0]        lk_kind,
  input logic              lk_pred_taken,
  input logic              lk_ret_valid,
  input logic              rs_valid,
  input logic              rs_ready,
  input logic              flush,
  input logic [HIST_W-1:0] hist,
  input logic [RAS_CW-1:0] ras_cnt
);
  assert_hist_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && lk_kind == 2'b01)
      |=> hist == {$past(hist[HIST_W-2:0]), $past(lk_pred_taken)});

  assert_hist_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind != 2'b01 && !(rs_valid && rs_ready)) |=> $stable(hist));

  assert_flush_after_resolve_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(rs_valid && rs_ready));

  assert_flush_drains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !rs_ready);

  assert_ret_only_on_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ret_valid |-> (lk_valid && lk_kind == 2'b11));

  assert_stack_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_cnt <= RAS_CW'(RAS_DEPTH));

  assert_idle_accepts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_ready |-> lk_ready);
endmodule

bind ghist_predictor ghist_predictor_chk #(
  .HIST_W(HIST_W), .RAS_DEPTH(RAS_DEPTH), .RAS_CW(RAS_CW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .lk_kind       (lk_kind),
  .lk_pred_taken (lk_pred_taken),
  .lk_ret_valid  (lk_ret_valid),
  .rs_valid      (rs_valid),
  .rs_ready      (rs_ready),
  .flush         (flush),
  .hist          (hist_q),
  .ras_cnt       (ras_cnt)
);

// File: tb/ghist_predictor_test.sv
module ghist_predictor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [1:0]  lk_kind = 2'b00;
  logic [31:0] lk_ret_addr = '0;
  logic        lk_pred_taken;
  logic        lk_ret_valid;
  logic [31:0] lk_ret_target;
  logic        rs_valid = 1'b0;
  logic        rs_ready;
  logic        rs_taken = 1'b0;
  logic        flush;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ghist_predictor uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_kind(lk_kind),
    .lk_ret_addr(lk_ret_addr), .lk_pred_taken(lk_pred_taken),
    .lk_ret_valid(lk_ret_valid), .lk_ret_target(lk_ret_target),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_taken(rs_taken),
    .flush(flush)
  );

  // reference model built from the requirements
  int          m_ctr [256];
  logic [7:0]  m_hist;
  logic [31:0] m_ras [4];
  int          m_ptr, m_cnt;
  logic [7:0]  q_hist [4];
  logic        q_pred [4];
  int          q_ptr [4], q_cnt [4];
  int          q_n;
  logic        m_flush;

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) m_ctr[i] = 1;
    m_hist = '0; m_ptr = 0; m_cnt = 0; q_n = 0; m_flush = 1'b0;
  endfunction

  function automatic bit exp_mis(input logic rv, input logic rt);
    return rv && q_n > 0 && rt != q_pred[0];
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] k, input logic [31:0] a,
                      input logic rv, input logic rt, input string tag);
    bit e_lk_rdy, e_pred, e_rv, acc, racc, mis;
    @(negedge clk);
    lk_valid = v; lk_kind = k; lk_ret_addr = a; rs_valid = rv; rs_taken = rt;
    #1;
    e_lk_rdy = (q_n < 4) && !exp_mis(rv, rt);
    e_pred   = m_ctr[m_hist] >= 2;
    e_rv     = v && k == 2'b11 && m_cnt > 0;
    chk(lk_ready == e_lk_rdy, tag, "lk_ready R10", 32'(lk_ready), 32'(e_lk_rdy));
    chk(rs_ready == (q_n > 0), tag, "rs_ready R10", 32'(rs_ready), 32'(q_n > 0));
    chk(lk_pred_taken == e_pred, tag, "pred R2 R3 R4", 32'(lk_pred_taken), 32'(e_pred));
    chk(lk_ret_valid == e_rv, tag, "ret_valid R6 R8", 32'(lk_ret_valid), 32'(e_rv));
    if (e_rv) chk(lk_ret_target == m_ras[m_ptr], tag, "ret_target R6 R7",
                  lk_ret_target, m_ras[m_ptr]);
    chk(flush == m_flush, tag, "flush R5", 32'(flush), 32'(m_flush));
    @(posedge clk);
    acc  = v && e_lk_rdy;
    racc = rv && q_n > 0;
    mis  = exp_mis(rv, rt);
    if (racc) begin
      if (rt) begin if (m_ctr[q_hist[0]] < 3) m_ctr[q_hist[0]]++; end
      else    begin if (m_ctr[q_hist[0]] > 0) m_ctr[q_hist[0]]--; end
    end
    m_flush = mis;
    if (mis) begin
      m_hist = {q_hist[0][6:0], rt};
      m_ptr = q_ptr[0]; m_cnt = q_cnt[0]; q_n = 0;
    end else begin
      if (racc) begin
        for (int i = 0; i < 3; i++) begin
          q_hist[i] = q_hist[i+1]; q_pred[i] = q_pred[i+1];
          q_ptr[i] = q_ptr[i+1]; q_cnt[i] = q_cnt[i+1];
        end
        q_n--;
      end
      if (acc) begin
        case (k)
          2'b01: begin
            q_hist[q_n] = m_hist; q_pred[q_n] = e_pred;
            q_ptr[q_n] = m_ptr; q_cnt[q_n] = m_cnt; q_n++;
            m_hist = {m_hist[6:0], e_pred};
          end
          2'b10: begin
            m_ptr = (m_ptr + 1) % 4; m_ras[m_ptr] = a;
            if (m_cnt < 4) m_cnt++;
          end
          2'b11: if (m_cnt > 0) begin m_ptr = (m_ptr + 3) % 4; m_cnt--; end
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, weak not-taken, empty stack
    step(0, 2'b00, 0, 0, 0, "R1");
    step(1, 2'b11, 0, 0, 0, "R1 R8");
    // R6 R7: six calls overflow a four-deep stack, then six returns
    for (int i = 0; i < 6; i++) step(1, 2'b10, 32'h1000 + 32'(i) * 4, 0, 0, "R6 R7");
    for (int i = 0; i < 6; i++) step(1, 2'b11, 0, 0, 0, "R6 R7");
    // R8: empty pop leaves stack untouched
    step(1, 2'b11, 0, 0, 0, "R8");
    step(1, 2'b10, 32'hABCD, 0, 0, "R8");
    step(1, 2'b11, 0, 0, 0, "R8");
    step(1, 2'b11, 0, 0, 0, "R8");
    // R4: repeated taken outcomes saturate counters upward, then downward
    for (int i = 0; i < 12; i++) begin
      step(1, 2'b01, 0, 0, 0, "R4");
      step(0, 2'b00, 0, 1, 1, "R4 R5");
    end
    for (int i = 0; i < 12; i++) begin
      step(1, 2'b01, 0, 0, 0, "R4");
      step(0, 2'b00, 0, 1, 0, "R4 R5");
    end
    // R5 R9 R11: calls after a branch are undone by its mispredict
    step(1, 2'b10, 32'h2000, 0, 0, "R9");
    step(1, 2'b01, 0, 0, 0, "R9");
    step(1, 2'b10, 32'h3000, 0, 0, "R9");
    step(1, 2'b01, 0, 0, 0, "R11");
    step(1, 2'b10, 32'h4000, 0, 0, "R9");
    step(1, 2'b11, 0, 1, ~q_pred[0], "R5 R9 R10");
    step(1, 2'b11, 0, 0, 0, "R5 R9");
    step(1, 2'b11, 0, 0, 0, "R9");
    // R10 R11: fill checkpoints, fifth branch is held off, drain in order
    for (int i = 0; i < 5; i++) step(1, 2'b01, 0, 0, 0, "R10");
    for (int i = 0; i < 4; i++) step(1, 2'b10, 32'h50 + 32'(i), 1, q_pred[0], "R10 R11");
    step(0, 2'b00, 0, 1, 0, "R10");
    // R12: lookup and training on the same counter in the same cycle
    step(1, 2'b01, 0, 0, 0, "R12");
    for (int i = 0; i < 8; i++) step(1, 2'b01, 0, 1, q_pred[0], "R12");
    step(0, 2'b00, 0, 1, 1, "R12");
    // constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic v, rv, rt;
      logic [1:0] k;
      v  = ($urandom % 10) < 7;
      k  = 2'($urandom % 4);
      rv = ($urandom % 10) < 4;
      rt = (q_n > 0 && ($urandom % 4) != 0) ? q_pred[0] : 1'($urandom % 2);
      step(v, k, $urandom, rv, rt, "R2 R3 R12 rand");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule